// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Sticky Error Flags

This block turns an asynchronous serial line into bytes. It watches the line for a start bit and confirms each start bit at its middle. It then samples the data bits, an optional parity bit and the stop bit at the centre of each bit. Each received byte goes into a small first-in first-out buffer, and a host pops bytes from that buffer one at a time. An external baud-rate generator supplies a one-cycle tick at sixteen times the bit rate.

The block checks every character for three faults:
- a stop bit that is low,
- a parity bit that disagrees with the selected mode,
- a character that arrives while the buffer has no free slot.

Each fault sets its own sticky flag, and the host clears the flags through a bit mask. One interrupt output combines the buffer-not-empty condition and the three flags. Each of the four sources has its own enable, and a global enable gates them all.

Top module: `uart_rx_err`

## Requirements
- R1: A frame is a low start bit, then DATA_W data bits least significant first, then an optional parity bit, then a stop bit. Each bit lasts 16 ticks. A completed byte is written into the buffer. `rx_ready_o` is high while the buffer holds a byte. `rd_data_o` shows the oldest byte, and a pulse on `rd_i` removes it.
- R2: A stop bit sampled low sets `err_frame_o`. It is set at the same clock edge at which the character is written to the buffer.
- R3: `par_mode_i` selects the parity mode: 00 = no parity bit, 01 = even (data plus parity bit hold an even count of ones), 10 = odd, 11 = no parity bit. A parity bit that disagrees with the mode sets `err_par_o`. In modes 00 and 11 the frame has no parity bit and `err_par_o` is never set.
- R4: A character may complete while all FIFO_DEPTH slots are full and no read happens in that cycle. The character is then dropped, the buffered bytes and their order stay unchanged, and `err_ovr_o` is set. The frame and parity checks of the dropped character still update their own flags.
- R5: The flags stay set until cleared. `clr_i` bit 0 clears the frame flag, bit 1 the parity flag and bit 2 the overrun flag. Clearing one flag leaves the others unchanged.
- R6: If hardware sets a flag in the same cycle that `clr_i` clears it, the flag ends up set.
- R7: `irq_o` is high when `gie_i` is high and at least one enabled source is active. The enable bits of `ie_i` are: bit 0 buffer not empty, bit 1 frame, bit 2 parity, bit 3 overrun. With `gie_i` low, `irq_o` is low.
- R8: The receiver returns to idle without receiving anything if the line is low for less than half a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling tick, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| par_mode_i | input | 2 | Parity mode |
| rd_i | input | 1 | Pop the oldest buffered byte |
| rd_data_o | output | DATA_W | Oldest buffered byte |
| rx_ready_o | output | 1 | Buffer not empty |
| err_frame_o | output | 1 | Sticky framing error |
| err_par_o | output | 1 | Sticky parity error |
| err_ovr_o | output | 1 | Sticky overrun error |
| clr_i | input | 3 | Flag clear mask |
| ie_i | input | 4 | Per-source interrupt enables |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a flag clear that lands in exactly the cycle in which a bad stop bit sets that flag. The host cannot see when the stop bit is sampled.

The bench gets there by starting from an empty buffer and holding the frame clear high through a whole frame that ends in a low stop bit. It polls `rx_ready_o` on every falling edge. The edge at which `rx_ready_o` rises is the edge at which the flag was set while the clear was applied, so the bench checks `err_frame_o` there and only then drops the clear.

Overrun uses the same idea. The buffer is filled, and a further frame is sent without reads, so that the dropped byte and the retained order are both visible at `rd_data_o`.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
  } rx_state_e;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_RSVD = 2'b11
  } par_mode_e;

  localparam int unsigned FLAG_FRAME = 0;
  localparam int unsigned FLAG_PAR   = 1;
  localparam int unsigned FLAG_OVR   = 2;
  localparam int unsigned NUM_FLAGS  = 3;
endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        par_mode_i,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              frame_err_o,
  output logic              par_err_o
);
  localparam int unsigned CW = $clog2(OSR);
  localparam int unsigned BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  rx_state_e         state_q;
  par_mode_e         mode_q;
  logic [CW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [DATA_W-1:0] shreg_q;
  logic              par_bit_q;
  logic              par_en, exp_par;

  assign par_en  = (mode_q == PAR_EVEN) || (mode_q == PAR_ODD);
  assign exp_par = (mode_q == PAR_ODD) ? ~^shreg_q : ^shreg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= RX_IDLE;
      mode_q      <= PAR_NONE;
      cnt_q       <= '0;
      bit_q       <= '0;
      shreg_q     <= '0;
      par_bit_q   <= 1'b0;
      done_o      <= 1'b0;
      data_o      <= '0;
      frame_err_o <= 1'b0;
      par_err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i) begin
        unique case (state_q)
          RX_IDLE: begin
            if (!rxd_i) begin
              state_q <= RX_START;
              cnt_q   <= '0;
              mode_q  <= par_mode_e'(par_mode_i);
            end
          end
          RX_START: begin
            if (cnt_q == MID) begin
              // mid-bit confirm; a short glitch falls back to idle
              cnt_q   <= '0;
              bit_q   <= '0;
              state_q <= rxd_i ? RX_IDLE : RX_DATA;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_DATA: begin
            if (cnt_q == LAST) begin
              cnt_q   <= '0;
              shreg_q <= {rxd_i, shreg_q[DATA_W-1:1]};
              if (bit_q == LAST_BIT) state_q <= par_en ? RX_PAR : RX_STOP;
              else                   bit_q   <= bit_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_PAR: begin
            if (cnt_q == LAST) begin
              cnt_q     <= '0;
              par_bit_q <= rxd_i;
              state_q   <= RX_STOP;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          RX_STOP: begin
            if (cnt_q == LAST) begin
              cnt_q       <= '0;
              state_q     <= RX_IDLE;
              done_o      <= 1'b1;
              data_o      <= shreg_q;
              frame_err_o <= !rxd_i;
              par_err_o   <= par_en && (par_bit_q != exp_par);
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic         space_o,
  output logic [W-1:0] data_o,
  output logic         empty_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [W-1:0]    mem_q [DEPTH];
  logic [PW-1:0]   wr_q, rd_q;
  logic [CNTW-1:0] cnt_q;
  logic            do_pop, do_push, full;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNTW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign space_o = !full || do_pop;
  assign do_push = push_i && space_o;
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < int'(DEPTH); i++) mem_q[i] <= '0;
    end else begin
      if (do_push) begin
        mem_q[wr_q] <= data_i;
        wr_q        <= (wr_q == LAST_PTR) ? '0 : wr_q + 1'b1;
      end
      if (do_pop) rd_q <= (rd_q == LAST_PTR) ? '0 : rd_q + 1'b1;
      unique case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_FLAGS-1:0] set_i,
  input  logic [NUM_FLAGS-1:0] clr_i,
  input  logic                 ready_i,
  input  logic [NUM_FLAGS:0]   ie_i,
  input  logic                 gie_i,
  output logic [NUM_FLAGS-1:0] flag_o,
  output logic                 irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_i) | set_i;  // set beats clear
  end

  assign irq_o = gie_i && |(ie_i & {flag_o, ready_i});
endmodule

// File: rtl/uart_rx_err.sv
module uart_rx_err
  import uart_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned FIFO_DEPTH  = 2,
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              rxd_i,
  input  logic [1:0]        par_mode_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rx_ready_o,
  output logic              err_frame_o,
  output logic              err_par_o,
  output logic              err_ovr_o,
  input  logic [2:0]        clr_i,
  input  logic [3:0]        ie_i,
  input  logic              gie_i,
  output logic              irq_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic              rxd_s;
  logic              char_done, char_fe, char_pe, push_ok, fifo_empty;
  logic [DATA_W-1:0] char_data;
  logic [NUM_FLAGS-1:0] flag_set, flags;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
  end
  assign rxd_s = sync_q[SYNC_STAGES-1];

  uart_rx_sampler #(.DATA_W(DATA_W), .OSR(OSR)) u_sampler (
    .clk_i, .rst_ni, .tick_i,
    .rxd_i       (rxd_s),
    .par_mode_i,
    .done_o      (char_done),
    .data_o      (char_data),
    .frame_err_o (char_fe),
    .par_err_o   (char_pe)
  );

  uart_rx_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (char_done),
    .data_i  (char_data),
    .pop_i   (rd_i),
    .space_o (push_ok),
    .data_o  (rd_data_o),
    .empty_o (fifo_empty)
  );

  assign rx_ready_o = !fifo_empty;

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_FRAME] = char_done && char_fe;
    flag_set[FLAG_PAR]   = char_done && char_pe;
    flag_set[FLAG_OVR]   = char_done && !push_ok;
  end

  uart_rx_flags u_flags (
    .clk_i, .rst_ni,
    .set_i   (flag_set),
    .clr_i,
    .ready_i (rx_ready_o),
    .ie_i,
    .gie_i,
    .flag_o  (flags),
    .irq_o
  );

  assign err_frame_o = flags[FLAG_FRAME];
  assign err_par_o   = flags[FLAG_PAR];
  assign err_ovr_o   = flags[FLAG_OVR];
endmodule

// File: rtl/uart_rx_err_chk.sv
module uart_rx_err_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              char_done,
  input logic              char_fe,
  input logic              push_ok,
  input logic              rd_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rx_ready_o,
  input logic              err_frame_o,
  input logic              err_par_o,
  input logic              err_ovr_o,
  input logic [2:0]        clr_i,
  input logic [3:0]        ie_i,
  input logic              gie_i,
  input logic              irq_o
);
  AST_READY_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && push_ok && !rd_i |=> rx_ready_o);  // R1
  AST_FRAME_WITH_CHAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_frame_o) |-> $past(char_done));  // R2
  AST_OVR_DATA_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && !push_ok |=> $stable(rd_data_o) && err_ovr_o);  // R4
  AST_PAR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_par_o && !clr_i[1] |=> err_par_o);  // R5
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_done && char_fe |=> err_frame_o);  // R6
  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |-> !irq_o);  // R7
  AST_IRQ_OVR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_i && ie_i[3] && err_ovr_o |-> irq_o);  // R7
endmodule

bind uart_rx_err uart_rx_err_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .char_done(char_done), .char_fe(char_fe),
  .push_ok(push_ok), .rd_i(rd_i), .rd_data_o(rd_data_o), .rx_ready_o(rx_ready_o),
  .err_frame_o(err_frame_o), .err_par_o(err_par_o), .err_ovr_o(err_ovr_o),
  .clr_i(clr_i), .ie_i(ie_i), .gie_i(gie_i), .irq_o(irq_o)
);

// File: tb/uart_rx_err_tb.sv
`timescale 1ns/1ps
module uart_rx_err_tb;
  localparam int DW = 8;
  localparam int DEPTH = 2;
  localparam int BIT_CLKS = 64;

  logic clk = 0, rst_n = 0, tick = 0, rxd = 1, rd = 0, gie = 0;
  logic [1:0] pmode = 0;
  logic [2:0] clr = 0;
  logic [3:0] ie = 0;
  logic [DW-1:0] rd_data;
  logic rx_ready, e_fr, e_pa, e_ov, irq;

  uart_rx_err u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .par_mode_i(pmode),
    .rd_i(rd), .rd_data_o(rd_data), .rx_ready_o(rx_ready),
    .err_frame_o(e_fr), .err_par_o(e_pa), .err_ovr_o(e_ov),
    .clr_i(clr), .ie_i(ie), .gie_i(gie), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  int tcnt = 0;
  always @(posedge clk) begin
    tick <= (tcnt == 3);
    tcnt <= (tcnt == 3) ? 0 : tcnt + 1;
  end

  logic [DW-1:0] q[$];
  bit m_fe, m_pe, m_ov, finished;
  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare(string req);
    bit exp_irq;
    exp_irq = gie && ((ie[0] && q.size() != 0) || (ie[1] && m_fe) ||
                      (ie[2] && m_pe) || (ie[3] && m_ov));
    chk(rx_ready == (q.size() != 0), req, "ready", int'(rx_ready), int'(q.size() != 0));
    if (q.size() != 0) chk(rd_data == q[0], req, "data", int'(rd_data), int'(q[0]));
    chk(e_fr == m_fe, req, "frame flag", int'(e_fr), int'(m_fe));
    chk(e_pa == m_pe, req, "parity flag", int'(e_pa), int'(m_pe));
    chk(e_ov == m_ov, req, "overrun flag", int'(e_ov), int'(m_ov));
    chk(irq == exp_irq, req, "irq", int'(irq), int'(exp_irq));
  endtask

  task automatic watch(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare(req);
    end
  endtask

  task automatic drive_bit(logic v, int len);
    rxd = v;
    repeat (len) @(negedge clk);
  endtask

  // mode 1 even, 2 odd, else no parity bit
  task automatic send(logic [DW-1:0] d, int mode, bit bad_par, bit stop_low, bit watch_set);
    logic p;
    p = (mode == 2) ? ~^d : ^d;
    if (bad_par) p = ~p;
    @(negedge clk);
    drive_bit(1'b0, BIT_CLKS);
    for (int i = 0; i < DW; i++) drive_bit(d[i], BIT_CLKS);
    if (mode == 1 || mode == 2) drive_bit(p, BIT_CLKS);
    if (stop_low) begin
      rxd = 1'b0;
      for (int i = 0; i < BIT_CLKS; i++) begin
        if (i == 48) rxd = 1'b1;
        @(negedge clk);
        if (watch_set && clr != 0 && rx_ready) begin
          // R6: flag set at the edge where clear was also applied
          chk(e_fr == 1'b1, "R6", "set vs clear", int'(e_fr), 1);
          clr = 0;
        end
      end
    end else begin
      drive_bit(1'b1, BIT_CLKS);
    end
    if (stop_low) m_fe = 1;
    if ((mode == 1 || mode == 2) && bad_par) m_pe = 1;
    if (q.size() < DEPTH) q.push_back(d);
    else m_ov = 1;
  endtask

  task automatic pop();
    @(negedge clk) rd = 1;
    @(negedge clk) rd = 0;
    void'(q.pop_front());
  endtask

  task automatic clear(logic [2:0] mask);
    @(negedge clk) clr = mask;
    @(negedge clk) clr = 0;
    if (mask[0]) m_fe = 0;
    if (mask[1]) m_pe = 0;
    if (mask[2]) m_ov = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    watch(4, "R1 reset");
    gie = 1; ie = 4'b0001; pmode = 0;
    send(8'hA5, 0, 0, 0, 0);  watch(8, "R1 8N1");
    pop();                    watch(4, "R1 pop");
    pmode = 1;
    send(8'h3C, 1, 0, 0, 0);  watch(4, "R3 even ok");
    send(8'h3D, 1, 1, 0, 0);  watch(4, "R3 even bad");
    ie = 4'b0100;             watch(4, "R7 parity irq");
    send(8'hF0, 1, 0, 0, 0);  ie = 4'b1000; watch(4, "R4 overrun");
    pop();                    watch(4, "R4 order");
    pop();                    watch(4, "R4 drained");
    clear(3'b010);            watch(4, "R5 clear parity only");
    clear(3'b100);            watch(4, "R5 clear overrun");
    pmode = 2; ie = 4'b0100;
    send(8'h01, 2, 0, 0, 0);  watch(4, "R3 odd ok");
    send(8'h07, 2, 1, 0, 0);  watch(4, "R3 odd bad");
    pop(); pop(); clear(3'b010); watch(4, "R5");
    pmode = 3;
    send(8'h5A, 3, 0, 0, 0);  watch(4, "R3 reserved mode");
    pop();
    pmode = 0; ie = 4'b0010;
    send(8'h81, 0, 0, 1, 0);  watch(8, "R2 framing");
    gie = 0;                  watch(4, "R7 global off");
    gie = 1;                  pop(); watch(4, "R2 sticky");
    @(negedge clk) rxd = 0;
    repeat (20) @(negedge clk);
    rxd = 1;                  watch(200, "R8 glitch");
    send(8'h77, 0, 0, 0, 0);  watch(4, "R8 after glitch");
    pop();
    @(negedge clk) clr = 3'b001;
    m_fe = 0;
    send(8'h42, 0, 0, 1, 1);
    chk(clr == 0, "R6", "race observed", int'(clr), 0);
    clr = 0;                  watch(4, "R6 flag kept");
    pop();                    watch(4, "R1 final");
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule